// File: doc/BRIEF.md
# Boot Remap and Reset-Vector Loader

This block sits between a small processor core and its memory fabric and runs the start-up sequence. While reset is held the core is kept idle. When reset is released, the block latches the boot-select pins once. It maps the chosen memory (internal flash, system ROM or on-chip SRAM) into a window that starts at address zero. It then reads two words from the vector-table base through that window: the first becomes the initial stack pointer and the second the reset handler address. Only after both are captured does it let the core run.

Once the core runs, the block acts as an address translator for the core's accesses. Addresses inside the zero window are moved to the physical home of the boot memory. Physical addresses of every memory still reach that memory. Addresses that hit nothing complete at once with zero data. A vector-table base register can be written while the core runs, is forced to 128-byte alignment, and returns to zero on every reset.

Top module: `boot_remap_loader`

## Requirements
- R1: The boot pins are captured once, in the first cycle after the internal reset is released. Later changes of the pins have no effect on the zero window until the next reset.
- R2: Pin encoding: 2'b00 selects flash, 2'b01 selects system ROM, 2'b10 selects SRAM, and the reserved 2'b11 selects flash. `mem_sel` bit 0 marks flash, bit 1 system ROM and bit 2 SRAM.
- R3: A core address below 2^REGION_AW maps to the boot memory's base address plus the same offset, with the matching `mem_sel` bit set.
- R4: A core address inside a memory's physical range reaches that memory unchanged, with its own `mem_sel` bit set, whatever the boot selection.
- R5: After reset the block reads the base plus 0 and then the base plus 4. The first word read goes to `core_sp` and the second to `core_pc`.
- R6: Each start-up read holds `mem_req` and its address until `mem_ready` is seen, so any number of wait states is allowed.
- R7: `core_run` stays low until both vector words are captured. In the cycle it rises, `core_pc` and `core_sp` already hold the words. From then on `core_run`, `core_pc` and `core_sp` stay unchanged until reset.
- R8: The vector base `vtor_q` reads zero after every reset. A write stores `vtor_wdata` with bits 6:0 cleared. Writes are accepted only while `core_run` is high.
- R9: While running, a core access to an address outside all memories and outside the window raises no `mem_req`. It gets `core_ready` high in the same cycle and `core_rdata` of zero.
- R10: While `core_run` is low, `core_ready` stays low and core requests are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pins | input | 2 | Boot memory selection pins |
| core_req | input | 1 | Core access request |
| core_we | input | 1 | Core access is a write |
| core_addr | input | ADDR_W | Core access address |
| core_wdata | input | DATA_W | Core write data |
| core_rdata | output | DATA_W | Read data returned to the core |
| core_ready | output | 1 | Core access completes this cycle |
| mem_req | output | 1 | Request to the memory fabric |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Physical address after remapping |
| mem_wdata | output | DATA_W | Memory write data |
| mem_sel | output | 3 | One-hot target memory select |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| vtor_we | input | 1 | Vector base write strobe |
| vtor_wdata | input | ADDR_W | Vector base write value |
| vtor_q | output | ADDR_W | Current vector base |
| core_run | output | 1 | Core released to fetch |
| core_sp | output | DATA_W | Initial stack pointer |
| core_pc | output | DATA_W | Initial program counter |

## Verification
The bench builds the block with REGION_AW set to 12, so each memory and the zero window span 4 KB, and keeps the default 32-bit address and data widths and memory bases. With the smaller window, both the last word of the window (0xFFC) and the first address past it (0x1000, which falls in no memory) can be tested directly. Random reads can also cover the whole window and every physical range. The memory model inserts a random 0 to 3 wait states per request, which tests the hold behaviour of both start-up reads. All four pin codes, including the reserved one, are booted in turn.

// File: rtl/boot_pkg.sv
package boot_pkg;

  localparam int unsigned NUM_MEM = 3;

  typedef enum logic [1:0] {
    PIN_FLASH = 2'b00,
    PIN_ROM   = 2'b01,
    PIN_SRAM  = 2'b10,
    PIN_RSVD  = 2'b11
  } boot_pin_e;

  typedef enum logic [1:0] {
    ST_RESET,
    ST_READ_SP,
    ST_READ_PC,
    ST_RUN
  } boot_state_e;

  // Memory index: 0 flash, 1 system ROM, 2 SRAM; reserved code falls back to flash
  function automatic logic [1:0] pin_to_index(input logic [1:0] pins);
    case (pins)
      PIN_ROM:  return 2'd1;
      PIN_SRAM: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/boot_addr_remap.sv
module boot_addr_remap
  import boot_pkg::*;
#(
  parameter int unsigned                     AW        = 32,
  parameter int unsigned                     REGION_AW = 16,
  parameter logic [NUM_MEM*AW-1:0]           BASES     = '0
) (
  input  logic [AW-1:0]      addr_i,
  input  logic [1:0]         boot_idx_i,
  output logic [AW-1:0]      phys_o,
  output logic [NUM_MEM-1:0] sel_o,
  output logic               hit_o
);

  localparam int unsigned TAGW = AW - REGION_AW;

  logic            in_window;
  logic [TAGW-1:0] boot_tag;

  always_comb begin
    boot_tag = '0;
    for (int r = 0; r < NUM_MEM; r++) begin
      if (boot_idx_i == 2'(r)) begin
        boot_tag = BASES[r*AW+REGION_AW +: TAGW];
      end
    end
  end

  always_comb begin
    in_window = (addr_i[AW-1:REGION_AW] == '0);
    phys_o    = in_window ? {boot_tag, addr_i[REGION_AW-1:0]} : addr_i;
  end

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_match
    assign sel_o[g] = (phys_o[AW-1:REGION_AW] == BASES[g*AW+REGION_AW +: TAGW]);
  end

  assign hit_o = |sel_o;

endmodule

// File: rtl/boot_vec_fsm.sv
module boot_vec_fsm
  import boot_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    boot_pins_i,
  input  logic [AW-1:0] vtor_i,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic [1:0]    boot_idx_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] pc_o,
  output logic          run_o
);

  localparam logic [AW-1:0] WORD_STEP = AW'(DW / 8);

  boot_state_e state_q, state_d;
  logic [1:0]    idx_q;
  logic [DW-1:0] sp_q, pc_q;
  logic          idx_en, sp_en, pc_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET:   state_d = ST_READ_SP;
      ST_READ_SP: if (mem_ready_i) state_d = ST_READ_PC;
      ST_READ_PC: if (mem_ready_i) state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_comb begin
    idx_en = (state_q == ST_RESET);
    sp_en  = (state_q == ST_READ_SP) && mem_ready_i;
    pc_en  = (state_q == ST_READ_PC) && mem_ready_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= pin_to_index(boot_pins_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= mem_rdata_i;
    end
  end

  assign fetch_req_o  = (state_q == ST_READ_SP) || (state_q == ST_READ_PC);
  assign fetch_addr_o = (state_q == ST_READ_PC) ? vtor_i + WORD_STEP : vtor_i;
  assign boot_idx_o   = idx_q;
  assign sp_o         = sp_q;
  assign pc_o         = pc_q;
  assign run_o        = (state_q == ST_RUN);

endmodule

// File: rtl/boot_vtor_reg.sv
module boot_vtor_reg #(
  parameter int unsigned AW    = 32,
  parameter int unsigned ALIGN = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] q_o
);

  logic          wr_en;
  logic [AW-1:0] q_q;

  assign wr_en = run_i && we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (wr_en) begin
      q_q <= {wdata_i[AW-1:ALIGN], {ALIGN{1'b0}}};
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/boot_remap_loader.sv
module boot_remap_loader
  import boot_pkg::*;
#(
  parameter int unsigned   ADDR_W      = 32,
  parameter int unsigned   DATA_W      = 32,
  parameter int unsigned   REGION_AW   = 16,
  parameter int unsigned   VTOR_ALIGN  = 7,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter logic [31:0]   FLASH_BASE  = 32'h0800_0000,
  parameter logic [31:0]   ROM_BASE    = 32'h1FFF_0000,
  parameter logic [31:0]   SRAM_BASE   = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_pins,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [2:0]        mem_sel,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  input  logic              vtor_we,
  input  logic [ADDR_W-1:0] vtor_wdata,
  output logic [ADDR_W-1:0] vtor_q,
  output logic              core_run,
  output logic [DATA_W-1:0] core_sp,
  output logic [DATA_W-1:0] core_pc
);

  localparam logic [NUM_MEM*ADDR_W-1:0] BASES =
    {ADDR_W'(SRAM_BASE), ADDR_W'(ROM_BASE), ADDR_W'(FLASH_BASE)};

  logic              rst_sync_n;
  logic              fetch_req;
  logic [ADDR_W-1:0] fetch_addr;
  logic [1:0]        boot_idx;
  logic [ADDR_W-1:0] dec_addr;
  logic [ADDR_W-1:0] phys_addr;
  logic [NUM_MEM-1:0] dec_sel;
  logic              dec_hit;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  boot_vec_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .boot_pins_i  (boot_pins),
    .vtor_i       (vtor_q),
    .mem_ready_i  (mem_ready),
    .mem_rdata_i  (mem_rdata),
    .fetch_req_o  (fetch_req),
    .fetch_addr_o (fetch_addr),
    .boot_idx_o   (boot_idx),
    .sp_o         (core_sp),
    .pc_o         (core_pc),
    .run_o        (core_run)
  );

  boot_vtor_reg #(.AW(ADDR_W), .ALIGN(VTOR_ALIGN)) u_vtor (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (core_run),
    .we_i    (vtor_we),
    .wdata_i (vtor_wdata),
    .q_o     (vtor_q)
  );

  assign dec_addr = core_run ? core_addr : fetch_addr;

  boot_addr_remap #(.AW(ADDR_W), .REGION_AW(REGION_AW), .BASES(BASES)) u_remap (
    .addr_i     (dec_addr),
    .boot_idx_i (boot_idx),
    .phys_o     (phys_addr),
    .sel_o      (dec_sel),
    .hit_o      (dec_hit)
  );

  always_comb begin
    mem_addr   = phys_addr;
    mem_sel    = dec_sel;
    mem_wdata  = core_wdata;
    mem_req    = core_run ? (core_req && dec_hit) : fetch_req;
    mem_we     = core_run && core_req && core_we;
    core_ready = core_run && core_req && (dec_hit ? mem_ready : 1'b1);
    core_rdata = (core_run && dec_hit) ? mem_rdata : '0;
  end

endmodule

module boot_remap_loader_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req,
  input logic              core_ready,
  input logic [DATA_W-1:0] core_rdata,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [2:0]        mem_sel,
  input logic [ADDR_W-1:0] vtor_q,
  input logic              core_run,
  input logic [DATA_W-1:0] core_sp,
  input logic [DATA_W-1:0] core_pc,
  input logic [1:0]        boot_idx
);

  // R10
  idle_core_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |-> !core_ready);

  // R7
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> core_run);

  // R7
  vectors_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> ($stable(core_pc) && $stable(core_sp)));

  // R8
  vtor_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vtor_q[6:0] == 7'd0);

  // R8
  vtor_boot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |-> (vtor_q == '0));

  // R1
  pins_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> $stable(boot_idx));

  // R4
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_sel) == 1));

  // R6
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !core_run) |=> (mem_req && $stable(mem_addr)));

  // R9
  miss_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && core_req && (mem_sel == 3'b000)) |-> (core_ready && !mem_req && core_rdata == '0));

endmodule

bind boot_remap_loader boot_remap_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_req   (core_req),
  .core_ready (core_ready),
  .core_rdata (core_rdata),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_sel    (mem_sel),
  .vtor_q     (vtor_q),
  .core_run   (core_run),
  .core_sp    (core_sp),
  .core_pc    (core_pc),
  .boot_idx   (boot_idx)
);

// File: tb/boot_remap_loader_tb_top.sv
`timescale 1ns/1ps
module boot_remap_loader_tb_top;

  localparam int unsigned RAW = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  boot_pins;
  logic        core_req, core_we;
  logic [31:0] core_addr, core_wdata, core_rdata;
  logic        core_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  mem_sel;
  logic        mem_ready;
  logic        vtor_we;
  logic [31:0] vtor_wdata, vtor_q;
  logic        core_run;
  logic [31:0] core_sp, core_pc;

  int checks = 0;
  int errors = 0;
  int nrd = 0;
  logic [31:0] rd_addr [4];
  logic [2:0]  rd_sel  [4];
  int wait_cnt = 0;

  always #4 clk = ~clk;

  boot_remap_loader #(.REGION_AW(RAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .boot_pins(boot_pins),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_ready(core_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_sel(mem_sel), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .vtor_we(vtor_we), .vtor_wdata(vtor_wdata),
    .vtor_q(vtor_q), .core_run(core_run), .core_sp(core_sp), .core_pc(core_pc)
  );

  function automatic logic [31:0] base_of(input int r);
    case (r)
      1:       return 32'h1FFF_0000;
      2:       return 32'h2000_0000;
      default: return 32'h0800_0000;
    endcase
  endfunction

  function automatic int region_of(input logic [1:0] pins);
    if (pins == 2'b01) return 1;
    if (pins == 2'b10) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] mem_word(input logic [2:0] sel, input logic [31:0] a);
    return (a ^ 32'hC3A5_0000) + {29'd0, sel};
  endfunction

  assign mem_rdata = mem_word(mem_sel, mem_addr);

  // Memory model: random 0..3 wait states per request, updated just after the edge
  initial begin
    mem_ready = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (mem_ready) begin
        mem_ready = 1'b0;
        wait_cnt  = int'($urandom_range(0, 3));
      end else if (mem_req) begin
        if (wait_cnt == 0) mem_ready = 1'b1;
        else wait_cnt--;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready && !core_run && nrd < 4) begin
      rd_addr[nrd] = mem_addr;
      rd_sel[nrd]  = mem_sel;
      nrd++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic boot(input logic [1:0] pins, input bit poke_vtor);
    int r;
    logic [31:0] b;
    r = region_of(pins);
    b = base_of(r);
    @(negedge clk);
    rst_n = 1'b0;
    boot_pins = pins;
    core_req = 1'b0;
    vtor_we = poke_vtor;
    vtor_wdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R7", "run in reset", {31'd0, core_run}, 32'd0);
    chk("R8", "vtor in reset", vtor_q, 32'd0);
    nrd = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (core_run) break;
    end
    vtor_we = 1'b0;
    chk("R7", "reads done at release", nrd, 32'd2);
    chk("R5", "first read addr", rd_addr[0], b);
    chk("R5", "second read addr", rd_addr[1], b + 32'd4);
    chk("R2", "boot memory select", {29'd0, rd_sel[0]}, 32'd1 << r);
    chk("R5", "stack pointer", core_sp, mem_word(3'(1 << r), b));
    chk("R7", "pc at release", core_pc, mem_word(3'(1 << r), b + 32'd4));
    if (poke_vtor) chk("R8", "vtor write during boot ignored", vtor_q, 32'd0);
  endtask

  task automatic core_read(input string req, input logic [31:0] a, input int boot_r);
    logic [31:0] ep;
    logic [2:0]  es;
    logic        miss;
    if (a < (32'd1 << RAW)) ep = base_of(boot_r) | a;
    else ep = a;
    es = 3'd0;
    for (int r = 0; r < 3; r++)
      if ((ep >> RAW) == (base_of(r) >> RAW)) es = 3'(1 << r);
    miss = (es == 3'd0);
    @(negedge clk);
    core_req = 1'b1;
    core_we = 1'b0;
    core_addr = a;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (core_ready) break;
    end
    chk(req, "core ready", {31'd0, core_ready}, 32'd1);
    if (miss) begin
      chk("R9", "miss raises no request", {31'd0, mem_req}, 32'd0);
      chk("R9", "miss data", core_rdata, 32'd0);
    end else begin
      chk(req, "physical addr", mem_addr, ep);
      chk(req, "select", {29'd0, mem_sel}, {29'd0, es});
      chk(req, "read data", core_rdata, mem_word(es, ep));
    end
    @(negedge clk);
    core_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; boot_pins = 2'b00; core_req = 1'b0; core_we = 1'b0;
    core_addr = '0; core_wdata = '0; vtor_we = 1'b0; vtor_wdata = '0;

    // R10: core request before release is not served
    @(negedge clk);
    rst_n = 1'b1;
    core_req = 1'b1; core_addr = 32'h0;
    @(negedge clk);
    chk("R10", "ready before run", {31'd0, core_ready}, 32'd0);
    core_req = 1'b0;

    for (int p = 0; p < 4; p++) begin
      boot(2'(p), p == 2);
      core_read("R3", 32'h0000_0FFC, region_of(2'(p)));
      core_read("R9", 32'h0000_1000, region_of(2'(p)));
      for (int k = 0; k < 12; k++) begin
        int r;
        logic [31:0] off;
        r = int'($urandom_range(0, 2));
        off = {$urandom} & 32'h0000_0FFC;
        if ($urandom_range(0, 1) == 1) core_read("R3", off, region_of(2'(p)));
        else core_read("R4", base_of(r) | off, region_of(2'(p)));
      end
      core_read("R9", 32'h4000_0010, region_of(2'(p)));
    end

    // R1: pin change after boot leaves the window on the latched memory
    boot(2'b01, 1'b0);
    @(negedge clk);
    boot_pins = 2'b10;
    core_read("R1", 32'h0000_0004, 1);
    boot(2'b10, 1'b0);
    core_read("R1", 32'h0000_0004, 2);

    // R8: aligned write while running, cleared by reset
    @(negedge clk);
    vtor_we = 1'b1; vtor_wdata = 32'h2000_01FF;
    @(negedge clk);
    vtor_we = 1'b0;
    chk("R8", "aligned vtor write", vtor_q, 32'h2000_0180);
    boot(2'b00, 1'b0);
    chk("R8", "vtor after reset", vtor_q, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule